// File: doc/BRIEF.md
# Flash Page Load Sequencer

This block is a host-side controller that moves one page of a NAND-style flash device into the device's on-chip buffer RAM. It does this by driving the device's memory-mapped register bus. A single start pulse latches a die select, a block address, a page address and a sector address, together with a system configuration word and an interrupt-mode flag. The block then works through a fixed series of register accesses. First it programs the addresses and the buffer configuration. Next it writes the system configuration and issues the load command. It then polls the interrupt register until the completion bit makes a genuine low-to-high transition. After that it clears the interrupt, unless automatic clearing is selected. Last, it reads the four ECC status registers.

Each status word carries two 5-bit error codes, one for an even sector and one for an odd sector. The block unpacks these into eight codes on a held output bus, and then pulses `done` so that a downstream reader can fetch the buffer contents. If the completion bit does not rise within a configurable number of poll reads, the block sets a timeout flag and returns to idle without pulsing `done`.

Top module: `flash_load_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err_timeout`, `bus_wr_en` and `bus_rd_en` are low and `ecc_codes` is zero.
- R2: On an accepted start, the first six bus accesses are writes in this order. (1) Address F100h with die select in bit 15 and block address in the low bits. (2) F107h with sector address in the lowest bits and page address just above it. (3) F101h with die select in bit 15 and all other bits zero. (4) F200h with 0800h. (5) F221h with the system configuration word. (6) F220h with 0000h.
- R3: An access completes only on a clock edge where `bus_ready` is high. Until then the strobe, address and write data are held. Read and write strobes are never high together.
- R4: After the command write, the block reads F241h repeatedly. It leaves the polling state only when bit 15 reads as 1 after an earlier poll read in the same operation returned 0. A bit 15 already high on the first reads is not taken as completion.
- R5: With `int_auto` low, the poll that completes is followed by a write of 0000h to F241h. With `int_auto` high, this write is left out.
- R6: The block then reads FF00h, FF01h, FF02h and FF03h in that order. From the word read at FF00h+k, bits [4:0] become code 2k and bits [12:8] become code 2k+1. Code i appears on `ecc_codes[5i+4:5i]`.
- R7: `done` is high for exactly one cycle, in the cycle after the last status read completes. `ecc_codes` then holds its value until the next accepted start.
- R8: A start pulse while `busy` is high is ignored. The operation in progress keeps its latched inputs, and no further operation follows it.
- R9: If POLL_LIMIT poll reads complete without a completion edge, the block performs no further access, sets `err_timeout`, returns to idle and does not pulse `done`. The next accepted start clears `err_timeout`.
- R10: `busy` is high from the cycle after an accepted start until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled while idle |
| die_sel | input | 1 | Die select for two-die devices |
| blk_addr | input | BLK_W | Flash block address |
| page_addr | input | PAGE_W | Page within the block |
| sect_addr | input | SECT_W | Sector within the page |
| sys_cfg | input | 16 | System configuration word (includes ECC enable) |
| int_auto | input | 1 | High when the device clears its interrupt itself |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 16 | Register bus write data |
| bus_wr_en | output | 1 | Write strobe |
| bus_rd_en | output | 1 | Read strobe |
| bus_rdata | input | 16 | Register bus read data, valid with ready |
| bus_ready | input | 1 | Access completes on an edge where this is high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Poll limit reached without completion |
| ecc_codes | output | 8*CODE_W | Eight per-sector ECC error codes |

## Verification
When every access completes at once, `done` is due A clock edges after the edge that accepts start. A counts 6 setup writes, the poll reads, the optional clear and 4 status reads. Each stall cycle the bus model inserts moves it one edge later. The bench counts accesses and stalls in its own bus model, samples every output on the falling edge, and compares the edge at which `done` appears against that sum. Timeout, ignored starts and held codes are checked at the ports once `busy` has fallen: the count of accesses, the flags and the code bus must be as expected.

// File: rtl/flsq_pkg.sv
package flsq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_POLL,
      ST_CLEAR,
      ST_STAT,
      ST_DONE
   } flsq_state_e;

   // device register addresses used by the load sequence
   localparam logic [15:0] REG_BLOCK  = 16'hF100;
   localparam logic [15:0] REG_BUFSEL = 16'hF101;
   localparam logic [15:0] REG_PAGE   = 16'hF107;
   localparam logic [15:0] REG_BUFCFG = 16'hF200;
   localparam logic [15:0] REG_CMD    = 16'hF220;
   localparam logic [15:0] REG_SYSCFG = 16'hF221;
   localparam logic [15:0] REG_INT    = 16'hF241;
   localparam logic [15:0] REG_ECC0   = 16'hFF00;

   localparam logic [15:0] VAL_BUFCFG = 16'h0800;
   localparam logic [15:0] VAL_LOAD   = 16'h0000;
   localparam logic [15:0] VAL_INTCLR = 16'h0000;

   localparam int SETUP_STEPS = 6;
   localparam int STAT_REGS   = 4;
   localparam int ODD_LSB     = 8;

endpackage

// File: rtl/flsq_word_gen.sv
module flsq_word_gen
   import flsq_pkg::*;
#(
   parameter int BLK_W  = 10,
   parameter int PAGE_W = 6,
   parameter int SECT_W = 2
) (
   input  logic [2:0]        step,
   input  logic              die,
   input  logic [BLK_W-1:0]  blk,
   input  logic [PAGE_W-1:0] page,
   input  logic [SECT_W-1:0] sect,
   input  logic [15:0]       cfg,
   output logic [15:0]       addr,
   output logic [15:0]       data
);

   localparam int LOC_W = PAGE_W + SECT_W;

   always_comb begin
      addr = '0;
      data = '0;
      unique case (step)
         3'd0: begin
            addr = REG_BLOCK;
            data[BLK_W-1:0] = blk;
            data[15] = die;
         end
         3'd1: begin
            addr = REG_PAGE;
            data[LOC_W-1:0] = {page, sect};
         end
         3'd2: begin
            addr = REG_BUFSEL;
            data[15] = die;
         end
         3'd3: begin
            addr = REG_BUFCFG;
            data = VAL_BUFCFG;
         end
         3'd4: begin
            addr = REG_SYSCFG;
            data = cfg;
         end
         3'd5: begin
            addr = REG_CMD;
            data = VAL_LOAD;
         end
         default: begin
            addr = '0;
            data = '0;
         end
      endcase
   end

endmodule

// File: rtl/flsq_poll_timer.sv
module flsq_poll_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);

   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign expired = tick && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr || expired) cnt <= '0;
      else if (tick)           cnt <= cnt + 1'b1;
   end

   // R9: the poll count never passes the configured limit
   a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT));

endmodule

// File: rtl/flsq_ecc_collect.sv
module flsq_ecc_collect #(
   parameter int CODE_W = 5,
   parameter int NREG   = 4,
   localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     load,
   input  logic [IW-1:0]            idx,
   input  logic [CODE_W-1:0]        even_in,
   input  logic [CODE_W-1:0]        odd_in,
   output logic [2*NREG*CODE_W-1:0] codes
);

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      logic [CODE_W-1:0] ev_q, od_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ev_q <= '0;
            od_q <= '0;
         end else if (clr) begin
            ev_q <= '0;
            od_q <= '0;
         end else if (load && idx == IW'(g)) begin
            ev_q <= even_in;
            od_q <= odd_in;
         end
      end

      assign codes[(2*g)*CODE_W   +: CODE_W] = ev_q;
      assign codes[(2*g+1)*CODE_W +: CODE_W] = od_q;
   end

endmodule

// File: rtl/flash_load_seq.sv
module flash_load_seq
   import flsq_pkg::*;
#(
   parameter int BLK_W      = 10,
   parameter int PAGE_W     = 6,
   parameter int SECT_W     = 2,
   parameter int CODE_W     = 5,
   parameter int POLL_LIMIT = 4096,
   parameter int INT_BIT    = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  die_sel,
   input  logic [BLK_W-1:0]      blk_addr,
   input  logic [PAGE_W-1:0]     page_addr,
   input  logic [SECT_W-1:0]     sect_addr,
   input  logic [15:0]           sys_cfg,
   input  logic                  int_auto,
   output logic [15:0]           bus_addr,
   output logic [15:0]           bus_wdata,
   output logic                  bus_wr_en,
   output logic                  bus_rd_en,
   input  logic [15:0]           bus_rdata,
   input  logic                  bus_ready,
   output logic                  busy,
   output logic                  done,
   output logic                  err_timeout,
   output logic [8*CODE_W-1:0]   ecc_codes
);

   localparam int STEP_W = 3;
   localparam int STAT_IW = $clog2(STAT_REGS);
   localparam logic [STEP_W-1:0] SETUP_LAST = STEP_W'(SETUP_STEPS - 1);
   localparam logic [STEP_W-1:0] STAT_LAST  = STEP_W'(STAT_REGS - 1);

   // elaboration-time parameter checks
   if (BLK_W < 1 || BLK_W > 15) begin : g_bad_blk
      $error("BLK_W must lie in 1..15");
   end
   if (PAGE_W + SECT_W > 16 || PAGE_W < 1 || SECT_W < 1) begin : g_bad_loc
      $error("page and sector fields must fit one 16-bit word");
   end
   if (CODE_W < 1 || CODE_W > ODD_LSB) begin : g_bad_code
      $error("CODE_W must lie in 1..8");
   end
   if (INT_BIT < 0 || INT_BIT > 15) begin : g_bad_int
      $error("INT_BIT must address a bit of the data bus");
   end
   if (POLL_LIMIT < 2) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 2");
   end

   flsq_state_e       state;
   logic [STEP_W-1:0] step;
   logic              seen_low;
   logic              die_q, auto_q;
   logic [BLK_W-1:0]  blk_q;
   logic [PAGE_W-1:0] page_q;
   logic [SECT_W-1:0] sect_q;
   logic [15:0]       cfg_q;
   logic              err_q;

   logic [15:0] gen_addr, gen_data;
   logic        acc, accept, poll_tick, poll_expired, int_bit;
   logic        unused_rdata_bits;

   assign accept    = (state == ST_IDLE) && start;
   assign acc       = (bus_wr_en || bus_rd_en) && bus_ready;
   assign poll_tick = (state == ST_POLL) && acc;
   assign int_bit   = bus_rdata[INT_BIT];
   assign unused_rdata_bits = ^bus_rdata;

   flsq_word_gen #(
      .BLK_W (BLK_W),
      .PAGE_W(PAGE_W),
      .SECT_W(SECT_W)
   ) u_word_gen (
      .step(step),
      .die (die_q),
      .blk (blk_q),
      .page(page_q),
      .sect(sect_q),
      .cfg (cfg_q),
      .addr(gen_addr),
      .data(gen_data)
   );

   flsq_poll_timer #(
      .LIMIT(POLL_LIMIT)
   ) u_poll_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state != ST_POLL),
      .tick   (poll_tick),
      .expired(poll_expired)
   );

   flsq_ecc_collect #(
      .CODE_W(CODE_W),
      .NREG  (STAT_REGS)
   ) u_ecc_collect (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .load   ((state == ST_STAT) && acc),
      .idx    (step[STAT_IW-1:0]),
      .even_in(bus_rdata[CODE_W-1:0]),
      .odd_in (bus_rdata[ODD_LSB +: CODE_W]),
      .codes  (ecc_codes)
   );

   // bus drive, decoded from the registered state
   always_comb begin
      bus_wr_en = (state == ST_SETUP) || (state == ST_CLEAR);
      bus_rd_en = (state == ST_POLL)  || (state == ST_STAT);
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (state)
         ST_SETUP: begin
            bus_addr  = gen_addr;
            bus_wdata = gen_data;
         end
         ST_POLL:  bus_addr = REG_INT;
         ST_CLEAR: begin
            bus_addr  = REG_INT;
            bus_wdata = VAL_INTCLR;
         end
         ST_STAT:  bus_addr = REG_ECC0 + 16'(step[STAT_IW-1:0]);
         default: begin
            bus_addr  = '0;
            bus_wdata = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         step     <= '0;
         seen_low <= 1'b0;
         die_q    <= 1'b0;
         auto_q   <= 1'b0;
         blk_q    <= '0;
         page_q   <= '0;
         sect_q   <= '0;
         cfg_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               die_q  <= die_sel;
               auto_q <= int_auto;
               blk_q  <= blk_addr;
               page_q <= page_addr;
               sect_q <= sect_addr;
               cfg_q  <= sys_cfg;
               err_q  <= 1'b0;
               step   <= '0;
               state  <= ST_SETUP;
            end
            ST_SETUP: if (acc) begin
               if (step == SETUP_LAST) begin
                  step     <= '0;
                  seen_low <= 1'b0;
                  state    <= ST_POLL;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_POLL: if (acc) begin
               if (int_bit && seen_low) begin
                  step  <= '0;
                  state <= auto_q ? ST_STAT : ST_CLEAR;
               end else begin
                  if (!int_bit) seen_low <= 1'b1;
                  if (poll_expired) begin
                     err_q <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_CLEAR: if (acc) begin
               step  <= '0;
               state <= ST_STAT;
            end
            ST_STAT: if (acc) begin
               if (step == STAT_LAST) state <= ST_DONE;
               else                   step  <= step + 1'b1;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state != ST_IDLE);
   assign done        = (state == ST_DONE);
   assign err_timeout = err_q;

   // R3: one strobe at a time
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_en && bus_rd_en));

   // R3: a stalled access holds its strobe, address and data
   a_r3_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr_en || bus_rd_en) && !bus_ready) |=>
         ($stable(bus_addr) && $stable(bus_wdata) &&
          $stable(bus_wr_en) && $stable(bus_rd_en)));

   // R5: an interrupt clear write carries zero and only happens in manual mode
   a_r5_clear_manual: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == REG_INT) |-> (bus_wdata == 16'h0000 && !auto_q));

   // R7: done lasts a single cycle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: codes hold while idle and no start arrives
   a_r7_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(ecc_codes));

   // R9: timeout and completion never coincide
   a_r9_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> !done);

   // R10: leaving idle only through an accepted start
   a_r10_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

// File: tb/flash_load_seq_bench.sv
`timescale 1ns/1ps
module flash_load_seq_bench;

   localparam int LIM = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        die_sel;
   logic [9:0]  blk_addr;
   logic [5:0]  page_addr;
   logic [1:0]  sect_addr;
   logic [15:0] sys_cfg;
   logic        int_auto;
   logic [15:0] bus_addr, bus_wdata, bus_rdata;
   logic        bus_wr_en, bus_rd_en, bus_ready;
   logic        busy, done, err_timeout;
   logic [39:0] ecc_codes;

   always #2.5 clk = ~clk;

   flash_load_seq #(.POLL_LIMIT(LIM)) u_flash_load_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .die_sel    (die_sel),
      .blk_addr   (blk_addr),
      .page_addr  (page_addr),
      .sect_addr  (sect_addr),
      .sys_cfg    (sys_cfg),
      .int_auto   (int_auto),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_wr_en  (bus_wr_en),
      .bus_rd_en  (bus_rd_en),
      .bus_rdata  (bus_rdata),
      .bus_ready  (bus_ready),
      .busy       (busy),
      .done       (done),
      .err_timeout(err_timeout),
      .ecc_codes  (ecc_codes)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // bus model state
   int n_acc, n_poll, stall_cfg, stall_left, stalls, stale_hi, low_n, seed;
   logic [15:0] log_a [64];
   logic [15:0] log_d [64];
   bit          log_w [64];

   // per-run observations
   int done_at, done_cnt;
   bit busy_seen, err_after_start;

   function automatic logic [4:0] code_of(int s, int i);
      return 5'((s * 7 + i * 13) % 32);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // register bus slave, acting on the falling edge
   always @(negedge clk) begin
      if (bus_wr_en || bus_rd_en) begin
         if (stall_left > 0) begin
            bus_ready = 1'b0;
            stall_left--;
            stalls++;
         end else begin
            bus_ready = 1'b1;
            stall_left = stall_cfg;
            if (n_acc < 64) begin
               log_a[n_acc] = bus_addr;
               log_d[n_acc] = bus_wr_en ? bus_wdata : 16'h0000;
               log_w[n_acc] = bus_wr_en;
            end
            n_acc++;
            if (bus_rd_en) begin
               if (bus_addr == 16'hF241) begin
                  bus_rdata = {(n_poll < stale_hi || n_poll >= stale_hi + low_n), 15'h1234};
                  n_poll++;
               end else if (bus_addr[15:8] == 8'hFF) begin
                  bus_rdata = {3'b111, code_of(seed, 2 * int'(bus_addr[1:0]) + 1),
                               3'b101, code_of(seed, 2 * int'(bus_addr[1:0]))};
               end else begin
                  bus_rdata = 16'hDEAD;
               end
            end
         end
      end else begin
         bus_ready = 1'b0;
      end
   end

   task automatic run_load(input bit die, input int blk, input int page, input int sect,
                           input logic [15:0] cfg, input bit auto_m, input int hi,
                           input int lo, input int st, input int sd, input int inj_at);
      int n;
      n_acc = 0; n_poll = 0; stalls = 0; stall_cfg = st; stall_left = st;
      stale_hi = hi; low_n = lo; seed = sd; done_at = -1; done_cnt = 0;
      @(negedge clk);
      die_sel = die; blk_addr = 10'(blk); page_addr = 6'(page); sect_addr = 2'(sect);
      sys_cfg = cfg; int_auto = auto_m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      busy_seen = busy;
      err_after_start = err_timeout;
      n = 0;
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
         if (n == inj_at) begin
            start = 1'b1;
            die_sel = ~die; blk_addr = ~10'(blk); page_addr = ~6'(page);
            sect_addr = ~2'(sect); sys_cfg = ~cfg; int_auto = ~auto_m;
         end else begin
            start = 1'b0;
         end
         if (done) begin
            done_cnt++;
            if (done_at < 0) done_at = n;
         end
      end
      start = 1'b0;
   endtask

   task automatic verify_ok(input bit die, input int blk, input int page, input int sect,
                            input logic [15:0] cfg, input bit auto_m, input int hi,
                            input int lo, input int sd);
      logic [15:0] ea [6];
      logic [15:0] ed [6];
      logic [39:0] ecodes;
      bit ok;
      int p, idx;
      ea[0] = 16'hF100; ed[0] = {die, 5'b0, 10'(blk)};
      ea[1] = 16'hF107; ed[1] = {8'h00, 6'(page), 2'(sect)};
      ea[2] = 16'hF101; ed[2] = {die, 15'h0000};
      ea[3] = 16'hF200; ed[3] = 16'h0800;
      ea[4] = 16'hF221; ed[4] = cfg;
      ea[5] = 16'hF220; ed[5] = 16'h0000;
      ok = 1;
      for (int i = 0; i < 6; i++)
         if (!(log_w[i] && log_a[i] == ea[i] && log_d[i] == ed[i])) ok = 0;
      check(ok, "R2", "setup write order/values", {log_a[1], log_d[1]}, {ea[1], ed[1]});
      check(busy_seen, "R10", "busy after start", busy_seen, 1);
      p = hi + lo + 1;
      check(n_poll == p, "R4", "poll read count", n_poll, p);
      ok = 1;
      for (int i = 6; i < 6 + p && i < 64; i++)
         if (log_w[i] || log_a[i] != 16'hF241) ok = 0;
      check(ok, "R4", "poll reads at F241", 0, 0);
      idx = 6 + p;
      if (!auto_m) begin
         check(log_w[idx] && log_a[idx] == 16'hF241 && log_d[idx] == 16'h0000,
               "R5", "interrupt clear write", {log_w[idx], log_a[idx]}, {1'b1, 16'hF241});
         idx++;
      end else begin
         check(!log_w[idx] && log_a[idx] == 16'hFF00, "R5", "no clear in auto mode",
               {log_w[idx], log_a[idx]}, {1'b0, 16'hFF00});
      end
      ok = 1;
      for (int k = 0; k < 4; k++)
         if (log_w[idx + k] || log_a[idx + k] != 16'hFF00 + 16'(k)) ok = 0;
      check(ok, "R6", "status read order", log_a[idx + 3], 16'hFF03);
      check(n_acc == idx + 4, "R6", "total accesses", n_acc, idx + 4);
      for (int i = 0; i < 8; i++) ecodes[5 * i +: 5] = code_of(sd, i);
      check(ecc_codes == ecodes, "R6", "ecc codes", ecc_codes, ecodes);
      check(done_cnt == 1, "R7", "done pulse count", done_cnt, 1);
      check(done_at == n_acc + stalls, "R7", "done cycle", done_at, n_acc + stalls);
      check(!err_timeout, "R9", "no timeout on success", err_timeout, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #750us;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      logic [39:0] held;
      int acc_before;
      rst_n = 1'b0; start = 1'b0; die_sel = 1'b0; blk_addr = '0; page_addr = '0;
      sect_addr = '0; sys_cfg = '0; int_auto = 1'b0; bus_rdata = '0; bus_ready = 1'b0;
      n_acc = 0; n_poll = 0; stall_cfg = 0; stall_left = 0; stalls = 0;
      stale_hi = 0; low_n = 1; seed = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !err_timeout && !bus_wr_en && !bus_rd_en && ecc_codes == 0,
            "R1", "reset outputs", {busy, done, err_timeout, bus_wr_en, bus_rd_en}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // basic load, manual interrupt clear
      run_load(1, 10'h2AB, 37, 2, 16'h40E0, 0, 0, 3, 0, 5, -1);
      verify_ok(1, 10'h2AB, 37, 2, 16'h40E0, 0, 0, 3, 5);

      // R7: codes held after completion
      held = ecc_codes;
      repeat (10) @(negedge clk);
      check(ecc_codes == held && !done && !busy, "R7", "codes held while idle", ecc_codes, held);

      // auto interrupt mode, stale high flag first (R4, R5)
      run_load(0, 10'h155, 12, 1, 16'h0001, 1, 4, 2, 0, 9, -1);
      verify_ok(0, 10'h155, 12, 1, 16'h0001, 1, 4, 2, 9);

      // R3: wait states on every access
      run_load(1, 10'h0F0, 63, 3, 16'hA5A5, 0, 2, 1, 2, 17, -1);
      verify_ok(1, 10'h0F0, 63, 3, 16'hA5A5, 0, 2, 1, 17);
      check(stalls == 2 * n_acc, "R3", "stall cycles absorbed", stalls, 2 * n_acc);

      // R8: start while busy ignored
      run_load(0, 10'h3C3, 5, 0, 16'h1234, 0, 1, 2, 0, 22, 3);
      verify_ok(0, 10'h3C3, 5, 0, 16'h1234, 0, 1, 2, 22);
      acc_before = n_acc;
      repeat (5) @(negedge clk);
      check(!busy && n_acc == acc_before, "R8", "no follow-on operation", n_acc, acc_before);

      // R9: timeout
      run_load(1, 10'h001, 1, 1, 16'h0000, 0, 0, 1000, 0, 3, -1);
      check(err_timeout, "R9", "timeout flag", err_timeout, 1);
      check(done_cnt == 0, "R9", "no done on timeout", done_cnt, 0);
      check(n_poll == LIM, "R9", "poll reads before timeout", n_poll, LIM);
      check(n_acc == 6 + LIM && !busy, "R9", "no access after timeout", n_acc, 6 + LIM);

      // R9: next start clears the flag
      run_load(0, 10'h222, 20, 2, 16'h0F0F, 1, 0, 1, 1, 30, -1);
      check(!err_after_start, "R9", "flag cleared by start", err_after_start, 0);
      verify_ok(0, 10'h222, 20, 2, 16'h0F0F, 1, 0, 1, 30);

      // R2: sweep of address field placement
      for (int d = 0; d < 2; d++)
         for (int pg = 0; pg < 64; pg += 9)
            for (int s = 0; s < 4; s++) begin
               run_load(d[0], (pg * 13 + s * 101 + d * 511) % 1024, pg, s,
                        16'(pg * 257 + s), (pg + s) % 2 == 1, s % 2, 1 + d, 0,
                        pg + s, -1);
               verify_ok(d[0], (pg * 13 + s * 101 + d * 511) % 1024, pg, s,
                         16'(pg * 257 + s), (pg + s) % 2 == 1, s % 2, 1 + d, pg + s);
            end

      summary();
   end

endmodule